// File: doc/BRIEF.md
# Configuration Request Packetizer

This block turns one configuration-space access into a configuration request packet for a PCI Express root port. A command gives the target bus, device/function, byte offset, access size, write data and a read/write flag. The block checks the target first. A legal command produces a three-dword request header, followed by the payload for a write, as a series of 64-bit beats with start and end markers. An illegal target produces a one-cycle reject code and no beats.

The block keeps a live copy of the root bus number. It chooses Type 0 or Type 1 by comparing the target bus with that number. It places the number in the requester ID. It updates the number when software reprograms the bus-number register of the root port. The packing of the payload depends on quadword alignment: an aligned write needs three beats, and every other request fits in two. Both the command side and the beat side use a valid/ready handshake.

Top module: `cfg_tlp_pack`

## Requirements
- R1: Header dword 0 has the format/type byte in bits 31:24 and the value 1 in bits 9:0. The byte is 0x04 for a read on the root bus, 0x44 for a write on the root bus, 0x05 for a read on another bus and 0x45 for a write on another bus. The comparison uses the root bus number held when the command is accepted.
- R2: Header dword 1 is {root bus, root port devfn (default 0x00), tag, 4'h0, byte enables}. The tag is 0x1D for a read and 0x10 for a write.
- R3: cmd_size encodes 0 as byte, 1 as word, and 2 or 3 as dword. The byte enables are 4'b0001 shifted left by offset[1:0] for a byte, 4'b0011 shifted left by offset[1:0] for a word (bits beyond bit 3 are dropped), and 4'hF for a dword.
- R4: Header dword 2 is {bus, devfn, 16-bit offset with bits 1:0 cleared}. The write payload is the write data masked to the access size and shifted left by 8×offset[1:0]. A read carries a zero payload.
- R5: Beat 1 carries dword 0 in bits 31:0 and dword 1 in bits 63:32, with beat_sop=1 and beat_eop=0.
- R6: A write whose offset has bit 2 clear takes three beats. Beat 2 is {32'h0, dword 2} with both markers low. Beat 3 is {32'h0, payload} with beat_eop=1.
- R7: Reads, and writes with offset bit 2 set, take two beats. Beat 2 is {payload, dword 2} with beat_eop=1.
- R8: A command to the root bus with device number devfn[7:3] nonzero is refused. rej_valid pulses for one cycle, rej_code is 1, and no beat is emitted.
- R9: A command to devfn 0 on the root bus at exactly offset 0x010 is refused with rej_code 2 and no beats. This check has priority over R8.
- R10: When the final beat of a write to the root bus, at dword-aligned offset 0x018, is taken, root_bus loads bits 7:0 of that write's payload. The new value governs later commands.
- R11: cmd_ready is low from the accepting edge until the final beat is taken. While beat_valid is high and beat_ready is low, the beat data and markers hold.
- R12: After reset, beat_valid=0, rej_valid=0, cmd_ready=1 and root_bus=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_bus | input | 8 | Target bus number |
| cmd_devfn | input | 8 | Target device/function |
| cmd_offset | input | 12 | Byte offset into configuration space |
| cmd_size | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| cmd_wdata | input | 32 | Write value, right-justified |
| rej_valid | output | 1 | One-cycle pulse: command refused |
| rej_code | output | 2 | 1 no device, 2 bad register |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Beat taken when high with beat_valid |
| beat_data | output | 64 | Beat contents |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |
| root_bus | output | 8 | Current root bus number |

## Verification
A corrupted held root bus number shows up in the next packet's first beat. The format byte flips between Type 0 and Type 1, and the requester ID in bits 63:48 is wrong. The check that follows a bus-number write catches this on root_bus before any further traffic. A wrong beat counter or packing state shows up as a missing, extra or misplaced beat with a bad end marker, and the scoreboard catches it on the beat where it happens. Back-pressure is applied throughout, so a register that drifts while stalled is caught one cycle after the drift.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

   localparam logic [1:0] REJ_NONE   = 2'd0;
   localparam logic [1:0] REJ_NODEV  = 2'd1;
   localparam logic [1:0] REJ_BADREG = 2'd2;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;

   localparam logic [7:0] FT_RD_LOCAL  = 8'h04;
   localparam logic [7:0] FT_WR_LOCAL  = 8'h44;
   localparam logic [7:0] FT_RD_REMOTE = 8'h05;
   localparam logic [7:0] FT_WR_REMOTE = 8'h45;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_HEAD = 2'd1,
      SQ_TAIL = 2'd2,
      SQ_DATA = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic [31:0] dw0;
      logic [31:0] dw1;
      logic [31:0] dw2;
      logic [31:0] pay;
      logic        three;
      logic        upd;
   } req_hdr_t;

endpackage

// File: rtl/cfg_tlp_screen.sv
module cfg_tlp_screen
   import cfg_tlp_pkg::*;
#(
   parameter int          OFS_W    = 12,
   parameter bit          HIDE_BAR = 1'b1,
   parameter int unsigned BAR_OFS  = 32'h10
) (
   input  logic [7:0]       bus,
   input  logic [7:0]       devfn,
   input  logic [OFS_W-1:0] ofs,
   input  logic [7:0]       root,
   output logic [1:0]       code
);
   localparam logic [OFS_W-1:0] BAR_MATCH = OFS_W'(BAR_OFS);

   logic on_root;
   logic dev_bad;
   logic bar_hit;

   assign on_root = (bus == root);
   assign dev_bad = on_root && (devfn[7:3] != 5'd0);

   generate
      if (HIDE_BAR) begin : g_hide
         assign bar_hit = on_root && (devfn == 8'h00) && (ofs == BAR_MATCH);
      end else begin : g_show
         assign bar_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (bar_hit)      code = REJ_BADREG;
      else if (dev_bad) code = REJ_NODEV;
      else              code = REJ_NONE;
   end
endmodule

// File: rtl/cfg_tlp_hdr.sv
module cfg_tlp_hdr
   import cfg_tlp_pkg::*;
#(
   parameter int          OFS_W    = 12,
   parameter logic [7:0]  RP_DEVFN = 8'h00,
   parameter logic [7:0]  RD_TAG   = 8'h1D,
   parameter logic [7:0]  WR_TAG   = 8'h10,
   parameter int unsigned PRIM_OFS = 32'h18
) (
   input  logic             wr,
   input  logic [7:0]       bus,
   input  logic [7:0]       devfn,
   input  logic [OFS_W-1:0] ofs,
   input  logic [1:0]       size,
   input  logic [31:0]      wdata,
   input  logic [7:0]       root,
   output req_hdr_t         hdr
);
   localparam logic [OFS_W-1:0] PRIM_MATCH = OFS_W'(PRIM_OFS);

   logic             on_root;
   logic [7:0]       fmt;
   logic [7:0]       be_wide;
   logic [31:0]      mask;
   logic [OFS_W-1:0] ofs_al;
   logic [4:0]       shamt;

   assign on_root = (bus == root);
   assign ofs_al  = {ofs[OFS_W-1:2], 2'b00};
   assign shamt   = {ofs[1:0], 3'b000};

   always_comb begin
      case ({wr, on_root})
         2'b01:   fmt = FT_RD_LOCAL;
         2'b11:   fmt = FT_WR_LOCAL;
         2'b10:   fmt = FT_WR_REMOTE;
         default: fmt = FT_RD_REMOTE;
      endcase
   end

   always_comb begin
      case (size)
         SZ_BYTE: begin
            be_wide = 8'h01 << ofs[1:0];
            mask    = 32'h0000_00FF;
         end
         SZ_WORD: begin
            be_wide = 8'h03 << ofs[1:0];
            mask    = 32'h0000_FFFF;
         end
         default: begin
            be_wide = 8'h0F;
            mask    = 32'hFFFF_FFFF;
         end
      endcase
   end

   always_comb begin
      hdr.dw0   = {fmt, 14'd0, 10'd1};
      hdr.dw1   = {root, RP_DEVFN, (wr ? WR_TAG : RD_TAG), 4'h0, be_wide[3:0]};
      hdr.dw2   = {bus, devfn, 16'(ofs_al)};
      hdr.pay   = wr ? ((wdata & mask) << shamt) : 32'h0;
      hdr.three = wr && !ofs[2];
      hdr.upd   = wr && on_root && (ofs_al == PRIM_MATCH);
   end
endmodule

// File: rtl/cfg_tlp_seq.sv
module cfg_tlp_seq
   import cfg_tlp_pkg::*;
#(
   parameter logic [7:0] ROOT_INIT = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   output logic        cmd_ready,
   input  logic [1:0]  rej_in,
   input  req_hdr_t    hdr,
   output logic        rej_valid,
   output logic [1:0]  rej_code,
   output logic        beat_valid,
   input  logic        beat_ready,
   output logic [63:0] beat_data,
   output logic        beat_sop,
   output logic        beat_eop,
   output logic [7:0]  root_q
);
   seq_state_t  state;
   logic [63:0] nxt2;
   logic [63:0] nxt3;
   logic        three_q;
   logic        upd_q;
   logic [7:0]  new_root;

   assign cmd_ready  = (state == SQ_IDLE);
   assign beat_valid = (state != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         beat_data <= 64'h0;
         beat_sop  <= 1'b0;
         beat_eop  <= 1'b0;
         nxt2      <= 64'h0;
         nxt3      <= 64'h0;
         three_q   <= 1'b0;
         upd_q     <= 1'b0;
         new_root  <= 8'h00;
         root_q    <= ROOT_INIT;
         rej_valid <= 1'b0;
         rej_code  <= REJ_NONE;
      end else begin
         rej_valid <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (cmd_valid) begin
                  if (rej_in != REJ_NONE) begin
                     rej_valid <= 1'b1;
                     rej_code  <= rej_in;
                  end else begin
                     beat_data <= {hdr.dw1, hdr.dw0};
                     beat_sop  <= 1'b1;
                     beat_eop  <= 1'b0;
                     nxt2      <= hdr.three ? {32'h0, hdr.dw2} : {hdr.pay, hdr.dw2};
                     nxt3      <= {32'h0, hdr.pay};
                     three_q   <= hdr.three;
                     upd_q     <= hdr.upd;
                     new_root  <= hdr.pay[7:0];
                     state     <= SQ_HEAD;
                  end
               end
            end
            SQ_HEAD: begin
               if (beat_ready) begin
                  beat_data <= nxt2;
                  beat_sop  <= 1'b0;
                  beat_eop  <= !three_q;
                  state     <= SQ_TAIL;
               end
            end
            SQ_TAIL: begin
               if (beat_ready) begin
                  if (three_q) begin
                     beat_data <= nxt3;
                     beat_eop  <= 1'b1;
                     state     <= SQ_DATA;
                  end else begin
                     beat_eop <= 1'b0;
                     state    <= SQ_IDLE;
                     if (upd_q) root_q <= new_root;
                  end
               end
            end
            default: begin
               if (beat_ready) begin
                  beat_eop <= 1'b0;
                  state    <= SQ_IDLE;
                  if (upd_q) root_q <= new_root;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cfg_tlp_pack.sv
module cfg_tlp_pack
   import cfg_tlp_pkg::*;
#(
   parameter int          OFS_W     = 12,
   parameter logic [7:0]  ROOT_INIT = 8'h00,
   parameter logic [7:0]  RP_DEVFN  = 8'h00,
   parameter logic [7:0]  RD_TAG    = 8'h1D,
   parameter logic [7:0]  WR_TAG    = 8'h10,
   parameter bit          HIDE_BAR  = 1'b1,
   parameter int unsigned BAR_OFS   = 32'h10,
   parameter int unsigned PRIM_OFS  = 32'h18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_write,
   input  logic [7:0]       cmd_bus,
   input  logic [7:0]       cmd_devfn,
   input  logic [OFS_W-1:0] cmd_offset,
   input  logic [1:0]       cmd_size,
   input  logic [31:0]      cmd_wdata,
   output logic             rej_valid,
   output logic [1:0]       rej_code,
   output logic             beat_valid,
   input  logic             beat_ready,
   output logic [63:0]      beat_data,
   output logic             beat_sop,
   output logic             beat_eop,
   output logic [7:0]       root_bus
);
   generate
      if (OFS_W < 6 || OFS_W > 16) begin : g_bad_ofs_w
         $error("cfg_tlp_pack: OFS_W must lie in 6..16");
      end
      if (BAR_OFS >= (1 << OFS_W) || PRIM_OFS >= (1 << OFS_W)) begin : g_bad_ofs
         $error("cfg_tlp_pack: special offsets must fit in OFS_W");
      end
   endgenerate

   logic [1:0] rej_now;
   req_hdr_t   hdr;

   cfg_tlp_screen #(
      .OFS_W   (OFS_W),
      .HIDE_BAR(HIDE_BAR),
      .BAR_OFS (BAR_OFS)
   ) u_screen (
      .bus  (cmd_bus),
      .devfn(cmd_devfn),
      .ofs  (cmd_offset),
      .root (root_bus),
      .code (rej_now)
   );

   cfg_tlp_hdr #(
      .OFS_W   (OFS_W),
      .RP_DEVFN(RP_DEVFN),
      .RD_TAG  (RD_TAG),
      .WR_TAG  (WR_TAG),
      .PRIM_OFS(PRIM_OFS)
   ) u_hdr (
      .wr   (cmd_write),
      .bus  (cmd_bus),
      .devfn(cmd_devfn),
      .ofs  (cmd_offset),
      .size (cmd_size),
      .wdata(cmd_wdata),
      .root (root_bus),
      .hdr  (hdr)
   );

   cfg_tlp_seq #(
      .ROOT_INIT(ROOT_INIT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .rej_in    (rej_now),
      .hdr       (hdr),
      .rej_valid (rej_valid),
      .rej_code  (rej_code),
      .beat_valid(beat_valid),
      .beat_ready(beat_ready),
      .beat_data (beat_data),
      .beat_sop  (beat_sop),
      .beat_eop  (beat_eop),
      .root_q    (root_bus)
   );
endmodule

// File: rtl/cfg_tlp_pack_chk.sv
module cfg_tlp_pack_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_ready,
   input logic        rej_valid,
   input logic        beat_valid,
   input logic        beat_ready,
   input logic [63:0] beat_data,
   input logic        beat_sop,
   input logic        beat_eop,
   input logic [7:0]  root_bus
);
   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data)
                                       && $stable(beat_sop) && $stable(beat_eop)));

   // R11
   busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !cmd_ready);

   // R8
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> !beat_valid);

   // R5
   sop_then_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && beat_sop) |=> (beat_valid && !beat_sop));

   // R6
   marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !(beat_sop && beat_eop));

   // R10
   root_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(root_bus) |-> $past(beat_valid && beat_ready && beat_eop));
endmodule

bind cfg_tlp_pack cfg_tlp_pack_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rej_valid (rej_valid),
   .beat_valid(beat_valid),
   .beat_ready(beat_ready),
   .beat_data (beat_data),
   .beat_sop  (beat_sop),
   .beat_eop  (beat_eop),
   .root_bus  (root_bus)
);

// File: tb/cfg_tlp_pack_test.sv
module cfg_tlp_pack_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_write = 1'b0;
   logic [7:0]  cmd_bus = 8'h0;
   logic [7:0]  cmd_devfn = 8'h0;
   logic [11:0] cmd_offset = 12'h0;
   logic [1:0]  cmd_size = 2'd0;
   logic [31:0] cmd_wdata = 32'h0;
   logic        rej_valid;
   logic [1:0]  rej_code;
   logic        beat_valid;
   logic        beat_ready = 1'b0;
   logic [63:0] beat_data;
   logic        beat_sop;
   logic        beat_eop;
   logic [7:0]  root_bus;

   always #5 clk = ~clk;

   cfg_tlp_pack uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_bus(cmd_bus), .cmd_devfn(cmd_devfn),
      .cmd_offset(cmd_offset), .cmd_size(cmd_size), .cmd_wdata(cmd_wdata),
      .rej_valid(rej_valid), .rej_code(rej_code), .beat_valid(beat_valid),
      .beat_ready(beat_ready), .beat_data(beat_data), .beat_sop(beat_sop),
      .beat_eop(beat_eop), .root_bus(root_bus)
   );

   typedef struct packed {
      logic        sop;
      logic        eop;
      logic [63:0] d;
      logic [7:0]  req;
   } exp_beat_t;

   typedef struct packed {
      logic [1:0] code;
      logic [7:0] req;
   } exp_rej_t;

   exp_beat_t beat_q[$];
   exp_rej_t  rej_q[$];
   int        total = 0;
   int        bad = 0;
   logic [7:0] model_root = 8'h00;
   logic       mon_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic       bp_on = 1'b1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Scoreboard driver: expected beats or reject computed from the requirements
   task automatic send(input logic w, input logic [7:0] bus, input logic [7:0] dfn,
                       input logic [11:0] ofs, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [7:0] req);
      logic [7:0]  fmt, tag;
      logic [7:0]  bew;
      logic [31:0] mask, dw0, dw1, dw2, pay;
      logic        on_root;
      exp_beat_t   e;
      exp_rej_t    r;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      on_root = (bus == model_root);
      if (on_root && dfn == 8'h00 && ofs == 12'h010) begin
         r.code = 2'd2; r.req = req;             // R9
         rej_q.push_back(r);
      end else if (on_root && dfn[7:3] != 5'd0) begin
         r.code = 2'd1; r.req = req;             // R8
         rej_q.push_back(r);
      end else begin
         fmt = on_root ? (w ? 8'h44 : 8'h04) : (w ? 8'h45 : 8'h05);   // R1
         tag = w ? 8'h10 : 8'h1D;                                    // R2
         case (sz)                                                   // R3
            2'd0:    begin bew = 8'h01 << ofs[1:0]; mask = 32'hFF;   end
            2'd1:    begin bew = 8'h03 << ofs[1:0]; mask = 32'hFFFF; end
            default: begin bew = 8'h0F;             mask = 32'hFFFF_FFFF; end
         endcase
         dw0 = {fmt, 24'h000001};
         dw1 = {model_root, 8'h00, tag, 4'h0, bew[3:0]};
         dw2 = {bus, dfn, 4'h0, ofs[11:2], 2'b00};                   // R4
         pay = w ? ((wd & mask) << (8 * ofs[1:0])) : 32'h0;
         e.sop = 1'b1; e.eop = 1'b0; e.d = {dw1, dw0}; e.req = req;  // R5
         beat_q.push_back(e);
         if (w && !ofs[2]) begin                                     // R6
            e.sop = 1'b0; e.eop = 1'b0; e.d = {32'h0, dw2};
            beat_q.push_back(e);
            e.eop = 1'b1; e.d = {32'h0, pay};
            beat_q.push_back(e);
         end else begin                                              // R7
            e.sop = 1'b0; e.eop = 1'b1; e.d = {pay, dw2};
            beat_q.push_back(e);
         end
         if (w && on_root && {ofs[11:2], 2'b00} == 12'h018)          // R10
            model_root = pay[7:0];
      end
      cmd_write = w; cmd_bus = bus; cmd_devfn = dfn; cmd_offset = ofs;
      cmd_size = sz; cmd_wdata = wd; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while ((beat_q.size() != 0 || rej_q.size() != 0 || beat_valid) && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(beat_q.size() == 0 && rej_q.size() == 0, "R11", "queues drained",
            64'(beat_q.size() + rej_q.size()), 64'd0);
   endtask

   // Monitor: pops expected items as beats are taken; drives back-pressure
   logic        stall_seen = 1'b0;
   logic [65:0] stall_val = '0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (stall_seen) begin
            // R11: stalled beat must hold
            check(beat_valid && {beat_sop, beat_eop, beat_data} == stall_val, "R11",
                  "stalled beat held", beat_data, stall_val[63:0]);
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         beat_ready = bp_on ? lfsr[0] | lfsr[3] : 1'b1;
         if (beat_valid) begin
            // R11: no command accepted while busy
            check(!cmd_ready, "R11", "cmd_ready low while busy", 64'(cmd_ready), 64'd0);
         end
         stall_seen = beat_valid && !beat_ready;
         stall_val  = {beat_sop, beat_eop, beat_data};
         if (beat_valid && beat_ready) begin
            if (beat_q.size() == 0) begin
               check(1'b0, "R8", "unexpected beat", beat_data, 64'h0);
            end else begin
               exp_beat_t e;
               e = beat_q.pop_front();
               check({beat_sop, beat_eop, beat_data} == {e.sop, e.eop, e.d},
                     $sformatf("R%0d", e.req), "beat",
                     {beat_data[63:2], beat_sop, beat_eop}, {e.d[63:2], e.sop, e.eop});
            end
         end
         if (rej_valid) begin
            if (rej_q.size() == 0) begin
               check(1'b0, "R8", "unexpected reject", 64'(rej_code), 64'd0);
            end else begin
               exp_rej_t r;
               r = rej_q.pop_front();
               check(rej_code == r.code, $sformatf("R%0d", r.req), "reject code",
                     64'(rej_code), 64'(r.code));
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check(!beat_valid && !rej_valid && cmd_ready && root_bus == 8'h00, "R12",
            "reset state", {53'h0, beat_valid, rej_valid, cmd_ready, root_bus},
            {53'h0, 3'b001, 8'h00});
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      send(1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 8'd1);          // R1 type 0 read
      send(1'b0, 8'h01, 8'h08, 12'h105, 2'd0, 32'h0, 8'd3);          // R3 byte, type 1 read
      send(1'b1, 8'h00, 8'h00, 12'h006, 2'd1, 32'hCAFE_1234, 8'd7);  // R7 word write, 2 beats
      send(1'b1, 8'h02, 8'h11, 12'h020, 2'd2, 32'hDEAD_BEEF, 8'd6);  // R6 aligned write
      send(1'b1, 8'h01, 8'h00, 12'h041, 2'd0, 32'h0000_00A5, 8'd4);  // R4 shifted byte
      send(1'b1, 8'h05, 8'h07, 12'h0C7, 2'd1, 32'h0000_BEEF, 8'd3);  // R3 word at offset 3
      send(1'b1, 8'h00, 8'h08, 12'h000, 2'd2, 32'h1, 8'd8);          // R8 device 1 refused
      send(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 8'd9);          // R9 bar read refused
      send(1'b1, 8'h00, 8'h00, 12'h010, 2'd2, 32'hFFFF_FFFF, 8'd9);  // R9 bar write refused
      send(1'b0, 8'h00, 8'h00, 12'h011, 2'd0, 32'h0, 8'd9);          // R9 only exact offset
      drain();
      send(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0005_0403, 8'd10); // R10 root update
      drain();
      check(root_bus == 8'h03, "R10", "root bus loaded", 64'(root_bus), 64'h03);
      send(1'b0, 8'h03, 8'h00, 12'h004, 2'd2, 32'h0, 8'd10);         // R10 now type 0
      send(1'b0, 8'h00, 8'h08, 12'h004, 2'd2, 32'h0, 8'd10);         // R10 old root now type 1
      send(1'b1, 8'h03, 8'h10, 12'h000, 2'd2, 32'h0, 8'd8);          // R8 on new root
      send(1'b1, 8'h03, 8'h00, 12'h018, 2'd1, 32'h0000_0009, 8'd10); // R10 second update
      drain();
      check(root_bus == 8'h09, "R10", "root bus reloaded", 64'(root_bus), 64'h09);
      send(1'b0, 8'h04, 8'h00, 12'h018, 2'd2, 32'h0, 8'd10);         // R10 read: no update
      drain();
      check(root_bus == 8'h09, "R10", "read leaves root", 64'(root_bus), 64'h09);
      for (int i = 0; i < 40; i++) begin                             // R11 mixed traffic
         send(i[0], 8'(i % 11), 8'(i * 5), 12'(i * 37 + 3), 2'(i % 4),
              32'h1357_9BDF ^ 32'(i * 32'h0101_0101), 8'd11);
      end
      bp_on = 1'b0;
      send(1'b1, 8'h07, 8'h00, 12'h100, 2'd2, 32'h0BAD_F00D, 8'd6);  // R6 no stall
      drain();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule